// File: doc/BRIEF.md
# Logical-Device Configuration Register File

This block holds the configuration state of a multi-function I/O controller whose functions are grouped into numbered logical devices. Software reaches it through two byte-wide ports. The index port latches a register address. The data port then reads or writes that register. Addresses below 0x30 are global. Global register 0x07 names the logical device, and addresses from 0x30 upward fall in that device's own register page.

Only the registers that later logic decodes are stored: the activate byte (0x30), the two base-address pairs (0x60/0x61 and 0x62/0x63) and the interrupt select (0x70) of each device, plus global registers 0x07 and 0x22. The block filters data-port writes by device number and register range. From the stored state it decodes three I/O windows: the power-management device's primary and auxiliary ranges, and the serial-bus device's 4-byte range. It also supplies the power-management interrupt number. Every decoded window is range-checked against a window that depends on the size of that device's decode block. A base outside the window disables the window rather than moving it.

Top module: `sio_ldcfg`

## Requirements
- R1: After reset every stored register reads 0, the index reads 0, every window enable is 0, every window base output is 0 and the interrupt output is 0.
- R2: A write with port_sel=0 loads the index, which reads back on port_sel=0. A write with port_sel=1 stores into the indexed register, which reads back on port_sel=1 at the next cycle. Global register 0x07 selects the logical device whose page is addressed by indexes 0x30 and above.
- R3: Data-port writes to any page register are ignored while the selected device number is above 0x0A; no low-bit aliasing onto devices 0..0x0A occurs (e.g. 0x1A does not reach 0x0A).
- R4: Data-port writes to page registers of devices 1, 2 and 7 are ignored; their registers keep reading 0.
- R5: Data-port writes to indexes 0x70..0x7F are ignored when the selected device number is below 4; for devices 4 and above a write to 0x70 is stored.
- R6: The primary power-management window (device 0x0A) has base {reg 0x60, reg 0x61} (high byte first). It is enabled only when that device's 0x30 is nonzero and the base lies in 0x0100..0x0FF0 inclusive. acpi_pri_base shows the base when enabled and 0 otherwise.
- R7: The auxiliary power-management window has base {reg 0x62, reg 0x63} of device 0x0A. It is enabled only when that device's 0x30 is nonzero and the base lies in 0x0100..0x0FF8 inclusive. acpi_aux_base shows the base when enabled and 0 otherwise.
- R8: acpi_irq equals register 0x70 of device 0x0A. Together with the other decoded outputs it changes only in the cycle after a data-port write and is stable otherwise.
- R9: The serial-bus window (device 9, base {0x60, 0x61}) is enabled only when that device's 0x30 is nonzero, bit 6 of global 0x22 is 1 and the base lies in 0x0100..0x0FFC inclusive. ab_base shows the base when enabled and 0 otherwise.
- R10: A data-port write of a value with bit 0 set to device 9's register 0x30 also sets bit 6 of global 0x22. A value with bit 0 clear leaves 0x22 unchanged. Software may clear that bit by writing 0x22 directly.
- R11: Writes to global indexes other than 0x07 and 0x22, and to page indexes other than 0x30, 0x60..0x63 and 0x70, are discarded; those indexes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the port chosen by port_sel |
| port_sel | input | 1 | 0 = index port, 1 = data port |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the port chosen by port_sel (combinational) |
| acpi_pri_en | output | 1 | Primary power-management window enabled |
| acpi_pri_base | output | 16 | Primary window base, 0 when disabled |
| acpi_aux_en | output | 1 | Auxiliary power-management window enabled |
| acpi_aux_base | output | 16 | Auxiliary window base, 0 when disabled |
| acpi_irq | output | 8 | Interrupt number for the power-management device |
| ab_en | output | 1 | Serial-bus window enabled |
| ab_base | output | 16 | Serial-bus window base, 0 when disabled |

## Verification
The bench builds the block with its default parameters: eleven stored devices, the power-management device at 0x0A, the serial-bus device at 9, devices 1, 2 and 7 locked and the interrupt guard at device 4. With only eleven stored pages, selecting device numbers such as 0x1A or 0xFF tests that the device-number filter compares the whole byte and does not wrap onto a real page. The window bounds 0x0FF0, 0x0FF8 and 0x0FFC sit one step apart in the low nibble, so the directed edge values separate the three windows. Random traffic over the select, activate, base and interrupt registers then mixes these cases.

// File: rtl/sio_ldcfg.sv
module sio_ldcfg #(
  parameter int          NUM_LD      = 11,
  parameter int          ACPI_LD     = 10,
  parameter int          AB_LD       = 9,
  parameter int          IRQ_MIN_LD  = 4,
  parameter logic [15:0] LOCK_MASK   = 16'h0086,
  parameter logic [15:0] WIN_LO      = 16'h0100,
  parameter logic [15:0] PRI_HI      = 16'h0FF0,
  parameter logic [15:0] AUX_HI      = 16'h0FF8,
  parameter logic [15:0] AB_HI       = 16'h0FFC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        port_sel,
  input  logic [7:0]  wr_data,
  output logic [7:0]  rd_data,
  output logic        acpi_pri_en,
  output logic [15:0] acpi_pri_base,
  output logic        acpi_aux_en,
  output logic [15:0] acpi_aux_base,
  output logic [7:0]  acpi_irq,
  output logic        ab_en,
  output logic [15:0] ab_base
);
  localparam int LW = (NUM_LD > 1) ? $clog2(NUM_LD) : 1;

  logic [7:0] idx_q, sel_q, g22_q;
  logic [7:0] act_q [NUM_LD];
  logic [7:0] bh_q  [NUM_LD];
  logic [7:0] bl_q  [NUM_LD];
  logic [7:0] sh_q  [NUM_LD];
  logic [7:0] sl_q  [NUM_LD];
  logic [7:0] irq_q [NUM_LD];

  wire [LW-1:0] ld     = sel_q[LW-1:0];
  wire          ld_in  = ({24'd0, sel_q} < NUM_LD);
  wire          locked = (sel_q < 8'd16) && LOCK_MASK[sel_q[3:0]];
  wire          irq_blk = (idx_q[7:4] == 4'h7) && ({24'd0, sel_q} < IRQ_MIN_LD);
  wire          dwr    = wr_en && port_sel;
  wire          pg_wr  = dwr && (idx_q >= 8'h30) && ld_in && !locked && !irq_blk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      sel_q <= '0;
      g22_q <= '0;
      for (int i = 0; i < NUM_LD; i++) begin
        act_q[i] <= '0; bh_q[i] <= '0; bl_q[i] <= '0;
        sh_q[i]  <= '0; sl_q[i] <= '0; irq_q[i] <= '0;
      end
    end else if (wr_en && !port_sel) begin
      idx_q <= wr_data;
    end else if (dwr && idx_q < 8'h30) begin
      if (idx_q == 8'h07) sel_q <= wr_data;
      if (idx_q == 8'h22) g22_q <= wr_data;
    end else if (pg_wr) begin
      case (idx_q)
        8'h30: begin
          act_q[ld] <= wr_data;
          if ({24'd0, sel_q} == AB_LD && wr_data[0]) g22_q[6] <= 1'b1;
        end
        8'h60: bh_q[ld]  <= wr_data;
        8'h61: bl_q[ld]  <= wr_data;
        8'h62: sh_q[ld]  <= wr_data;
        8'h63: sl_q[ld]  <= wr_data;
        8'h70: irq_q[ld] <= wr_data;
        default: ;
      endcase
    end
  end

  logic [7:0] page_rd;
  always_comb begin
    page_rd = '0;
    if (ld_in) begin
      case (idx_q)
        8'h30: page_rd = act_q[ld];
        8'h60: page_rd = bh_q[ld];
        8'h61: page_rd = bl_q[ld];
        8'h62: page_rd = sh_q[ld];
        8'h63: page_rd = sl_q[ld];
        8'h70: page_rd = irq_q[ld];
        default: page_rd = '0;
      endcase
    end
  end

  wire [7:0] glob_rd = (idx_q == 8'h07) ? sel_q :
                       (idx_q == 8'h22) ? g22_q : 8'h00;

  assign rd_data = !port_sel ? idx_q : (idx_q >= 8'h30) ? page_rd : glob_rd;

  wire [15:0] pri_b = {bh_q[ACPI_LD], bl_q[ACPI_LD]};
  wire [15:0] aux_b = {sh_q[ACPI_LD], sl_q[ACPI_LD]};
  wire [15:0] ab_b  = {bh_q[AB_LD], bl_q[AB_LD]};
  wire        acpi_on = |act_q[ACPI_LD];

  assign acpi_pri_en   = acpi_on && pri_b >= WIN_LO && pri_b <= PRI_HI;
  assign acpi_aux_en   = acpi_on && aux_b >= WIN_LO && aux_b <= AUX_HI;
  assign ab_en         = |act_q[AB_LD] && g22_q[6] && ab_b >= WIN_LO && ab_b <= AB_HI;
  assign acpi_pri_base = acpi_pri_en ? pri_b : 16'h0;
  assign acpi_aux_base = acpi_aux_en ? aux_b : 16'h0;
  assign ab_base       = ab_en ? ab_b : 16'h0;
  assign acpi_irq      = irq_q[ACPI_LD];

  p_high_ld_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && idx_q >= 8'h30 && sel_q > 8'h0A) |=>
      $stable({acpi_pri_base, acpi_aux_base, acpi_irq, ab_base, acpi_pri_en, acpi_aux_en, ab_en}));

  p_locked_ld_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && sel_q == 8'd1 && idx_q >= 8'h30) |=> $stable({act_q[1], bh_q[1], bl_q[1], irq_q[1]}));

  p_low_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && sel_q == 8'd3 && idx_q[7:4] == 4'h7) |=> $stable(irq_q[3]));

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dwr |=> $stable({acpi_pri_base, acpi_aux_base, acpi_irq, ab_base, acpi_pri_en, acpi_aux_en, ab_en}));

  p_ab_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr && sel_q == 8'(AB_LD) && idx_q == 8'h30 && wr_data[0]) |=> g22_q[6]);

  p_pri_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acpi_pri_en |-> (acpi_pri_base >= WIN_LO && acpi_pri_base <= PRI_HI));
endmodule

// File: tb/sim_sio_ldcfg.sv
module sim_sio_ldcfg;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, wr_en = 1'b0, port_sel = 1'b0;
  logic [7:0] wr_data = '0;
  wire  [7:0] rd_data, acpi_irq;
  wire        acpi_pri_en, acpi_aux_en, ab_en;
  wire [15:0] acpi_pri_base, acpi_aux_base, ab_base;

  sio_ldcfg u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .port_sel(port_sel), .wr_data(wr_data),
    .rd_data(rd_data), .acpi_pri_en(acpi_pri_en), .acpi_pri_base(acpi_pri_base),
    .acpi_aux_en(acpi_aux_en), .acpi_aux_base(acpi_aux_base), .acpi_irq(acpi_irq),
    .ab_en(ab_en), .ab_base(ab_base));

  int vecs = 0, bad = 0, cyc = 0;
  bit done = 0;
  int m_idx, m_sel, m_g22;
  int m_act[11], m_bh[11], m_bl[11], m_sh[11], m_sl[11], m_irq[11];

  function automatic void mwrite(bit p, int d);
    if (!p) m_idx = d;
    else if (m_idx < 'h30) begin
      if (m_idx == 'h07) m_sel = d;
      if (m_idx == 'h22) m_g22 = d;
    end else begin
      if (m_sel > 'h0A || m_sel == 1 || m_sel == 2 || m_sel == 7) return;
      if ((m_idx >> 4) == 7 && m_sel < 4) return;
      case (m_idx)
        'h30: begin m_act[m_sel] = d; if (m_sel == 9 && d[0]) m_g22 = m_g22 | 'h40; end
        'h60: m_bh[m_sel] = d;
        'h61: m_bl[m_sel] = d;
        'h62: m_sh[m_sel] = d;
        'h63: m_sl[m_sel] = d;
        'h70: m_irq[m_sel] = d;
        default: ;
      endcase
    end
  endfunction

  function automatic int mread(bit p);
    if (!p) return m_idx;
    if (m_idx < 'h30) return (m_idx == 'h07) ? m_sel : (m_idx == 'h22) ? m_g22 : 0;
    if (m_sel > 'h0A) return 0;
    case (m_idx)
      'h30: return m_act[m_sel];
      'h60: return m_bh[m_sel];
      'h61: return m_bl[m_sel];
      'h62: return m_sh[m_sel];
      'h63: return m_sl[m_sel];
      'h70: return m_irq[m_sel];
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put(bit p, int d);
    mwrite(p, d & 'hff);
    @(negedge clk);
    port_sel = p; wr_data = 8'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(string tag, bit p);
    port_sel = p;
    #2;
    chk(tag, int'(rd_data), mread(p));
  endtask

  task automatic reg_wr(int ld, int ix, int d);
    put(0, 'h07); put(1, ld); put(0, ix); put(1, d);
  endtask

  task automatic reg_rd(string tag, int ld, int ix);
    put(0, 'h07); put(1, ld); put(0, ix); rdchk(tag, 1);
  endtask

  task automatic outs(string tag);
    int pb, ab, xb, pe, ae, be;
    pb = m_bh[10] * 256 + m_bl[10];
    ab = m_sh[10] * 256 + m_sl[10];
    xb = m_bh[9] * 256 + m_bl[9];
    pe = (m_act[10] != 0 && pb >= 'h100 && pb <= 'hFF0) ? 1 : 0;
    ae = (m_act[10] != 0 && ab >= 'h100 && ab <= 'hFF8) ? 1 : 0;
    be = (m_act[9] != 0 && m_g22[6] && xb >= 'h100 && xb <= 'hFFC) ? 1 : 0;
    #2;
    chk({tag, " pri_en"}, int'(acpi_pri_en), pe);
    chk({tag, " pri_base"}, int'(acpi_pri_base), pe ? pb : 0);
    chk({tag, " aux_en"}, int'(acpi_aux_en), ae);
    chk({tag, " aux_base"}, int'(acpi_aux_base), ae ? ab : 0);
    chk({tag, " irq"}, int'(acpi_irq), m_irq[10]);
    chk({tag, " ab_en"}, int'(ab_en), be);
    chk({tag, " ab_base"}, int'(ab_base), be ? xb : 0);
  endtask

  function automatic int pick_ld();
    case ($urandom % 6)
      0: return 'h1A;
      1: return 'h0B + $urandom % 3;
      2: return $urandom % 256;
      default: return $urandom % 11;
    endcase
  endfunction

  function automatic int pick_idx();
    case ($urandom % 12)
      0, 1: return 'h07;
      2: return 'h22;
      3: return 'h30;
      4: return 'h60;
      5: return 'h61;
      6: return 'h62;
      7: return 'h63;
      8: return 'h70;
      9: return 'h70 + $urandom % 16;
      default: return $urandom % 256;
    endcase
  endfunction

  function automatic int pick_byte(int ix);
    if (ix == 'h07) return pick_ld();
    if (ix == 'h60 || ix == 'h62) begin
      case ($urandom % 4) 0: return 'h00; 1: return 'h01; 2: return 'h0F; default: return $urandom % 256; endcase
    end
    if (ix == 'h61 || ix == 'h63) begin
      case ($urandom % 5) 0: return 'hF0; 1: return 'hF8; 2: return 'hFC; 3: return 'hFF; default: return $urandom % 256; endcase
    end
    return $urandom % 256;
  endfunction

  initial begin
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    int ix;
    m_idx = 0; m_sel = 0; m_g22 = 0;
    for (int i = 0; i < 11; i++) begin
      m_act[i] = 0; m_bh[i] = 0; m_bl[i] = 0; m_sh[i] = 0; m_sl[i] = 0; m_irq[i] = 0;
    end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    outs("R1");
    rdchk("R1 index", 0);
    rdchk("R1 data", 1);

    put(0, 'h07); rdchk("R2 index", 0);
    put(1, 'h0A); rdchk("R2 select", 1);
    put(0, 'h30); put(1, 'h01); rdchk("R2 page", 1);

    reg_wr('h0A, 'h60, 'h00); reg_wr('h0A, 'h61, 'hFF); outs("R6 below");
    reg_wr('h0A, 'h60, 'h01); reg_wr('h0A, 'h61, 'h00); outs("R6 low edge");
    reg_wr('h0A, 'h60, 'h0F); reg_wr('h0A, 'h61, 'hF0); outs("R6 high edge");
    reg_wr('h0A, 'h61, 'hF1); outs("R6 above");
    reg_wr('h0A, 'h62, 'h0F); reg_wr('h0A, 'h63, 'hF8); outs("R7 high edge");
    reg_wr('h0A, 'h63, 'hF9); outs("R7 above");
    reg_wr('h0A, 'h63, 'h00); outs("R7 inside");
    reg_wr('h0A, 'h70, 'h05); outs("R8 irq");

    reg_wr('h0B, 'h30, 'h00); reg_wr('h1A, 'h30, 'h00); reg_wr('h1A, 'h70, 'h09);
    outs("R3 no alias");
    reg_rd("R3 act kept", 'h0A, 'h30);

    reg_wr(1, 'h60, 'h12); reg_rd("R4 ld1", 1, 'h60);
    reg_wr(2, 'h30, 'h01); reg_rd("R4 ld2", 2, 'h30);
    reg_wr(7, 'h70, 'h03); reg_rd("R4 ld7", 7, 'h70);

    reg_wr(3, 'h70, 'h04); reg_rd("R5 ld3 blocked", 3, 'h70);
    reg_wr(5, 'h70, 'h06); reg_rd("R5 ld5 stored", 5, 'h70);

    put(0, 'h22); put(1, 'h00);
    reg_wr(9, 'h30, 'h02); reg_rd("R10 bit0 clear", 9, 'h30);
    put(0, 'h22); rdchk("R10 g22 kept", 1);
    reg_wr(9, 'h30, 'h01); put(0, 'h22); rdchk("R10 g22 set", 1);

    reg_wr(9, 'h60, 'h0F); reg_wr(9, 'h61, 'hFC); outs("R9 edge");
    reg_wr(9, 'h61, 'hFD); outs("R9 above");
    reg_wr(9, 'h61, 'h00); put(0, 'h22); put(1, 'h00); outs("R9 global off");
    put(1, 'h40); reg_wr(9, 'h30, 'h00); outs("R9 inactive");

    put(0, 'h10); put(1, 'h55); rdchk("R11 global", 1);
    reg_wr(5, 'h65, 'h07); reg_rd("R11 page", 5, 'h65);

    for (int n = 0; n < 1500; n++) begin
      if ($urandom % 3 == 0) begin
        ix = pick_idx();
        put(0, ix);
      end
      put(1, pick_byte(m_idx));
      outs("R6 R7 R8 R9 random");
      rdchk("R2 R3 R4 R5 R10 R11 random", 1);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule